// File: doc/BRIEF.md
# Protected Memory Region Address Router

This block sits on the request path of a memory hub. For each incoming request it looks at the byte address, where the request came from (a processor or an inbound I/O agent), the request kind, and a per-request system-management qualifier bit. From these it picks a destination: main memory, the configuration space, MMIO, or a master abort. It also keeps a sticky error flag.

Two windows can be moved at run time. The first is a protected system-management segment that ends just below a programmable top pointer. Its size is chosen by a 2-bit code. The second is a 256 MB configuration window whose base is programmable. Both pointers take the top-of-low-memory value at reset. When a request falls in the configuration window, the block also returns the bus, device, function and register-offset fields decoded from the address.

Requests and decisions each use a valid/ready handshake. The decision is held in a one-entry output register until it is taken.

Top module: `pmr_addr_router`

## Requirements
- R1: The protected segment covers addresses from (top − size) up to, but not including, top. Size code 0, 1, 2 and 3 gives 512 KB, 1 MB, 2 MB and 4 MB. Route encoding: 0 = main memory, 1 = configuration, 2 = MMIO, 3 = abort.
- R2: Reset has three effects. Both the top pointer and the configuration base take the value of `tolm_i`. `rsp_valid` goes to 0. `err_o` goes to 0.
- R3: A request from a processor (`req_src`=0) that hits the segment is handled by its qualifier. With `req_smq`=1 it routes to main memory. With `req_smq`=0 it aborts and sets `err_o`.
- R4: Explicit writebacks (`req_kind`=2) and implicit writebacks (`req_kind`=3) from a processor that hit the segment always route to main memory, whatever the qualifier, and never set `err_o`.
- R5: An inbound request (`req_src`=1) that hits the segment aborts and does not set `err_o`.
- R6: A locked request (`req_kind`=4) whose byte span, from `req_addr` to `req_addr+req_len`, crosses the segment base or the segment top aborts and sets `err_o`. A locked request that does not cross a boundary is decoded like a read. Read is kind 0 and write is kind 1.
- R7: Any address whose bits above bit 27 equal the configuration base routes to configuration. It then returns bus = addr[27:20], device = addr[19:15], function = addr[14:12] and offset = addr[11:0]. On every other route these fields are zero.
- R8: Decode priority is fixed: the segment first, then the configuration window, then main memory for addresses below `tolm_i`, and MMIO for everything else.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at one edge is presented on the response outputs right after that edge. A response that has not been taken holds stable.
- R10: `err_o` stays set until a cycle with `err_clr`=1. If an error is set and cleared in the same cycle, the set wins.
- R11: A cycle with `prog_we`=1 writes `prog_data`, which is address bits [35:19]. With `prog_sel`=0 it writes the top pointer. With `prog_sel`=1 it writes the configuration base, taking the upper bits of `prog_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tolm_i | input | 36 | Top of low memory; also the reset value of both pointers |
| seg_size_i | input | 2 | Segment size code |
| prog_we | input | 1 | Pointer write strobe |
| prog_sel | input | 1 | 0 = top pointer, 1 = configuration base |
| prog_data | input | 17 | Pointer value, address bits [35:19] |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 36 | First byte address |
| req_len | input | 6 | Byte count minus one |
| req_src | input | 1 | 0 = processor, 1 = inbound |
| req_kind | input | 3 | 0 read, 1 write, 2 explicit writeback, 3 implicit writeback, 4 locked |
| req_smq | input | 1 | System-management qualifier |
| rsp_valid | output | 1 | Decision valid |
| rsp_ready | input | 1 | Decision taken |
| rsp_route | output | 2 | Route code |
| rsp_bus | output | 8 | Configuration bus field |
| rsp_dev | output | 5 | Configuration device field |
| rsp_fn | output | 3 | Configuration function field |
| rsp_off | output | 12 | Configuration register offset |
| err_o | output | 1 | Sticky error flag |
| err_clr | input | 1 | Clear pulse for the error flag |

## Verification
A wrong segment base or size code shows up on the first request placed just inside or just outside a segment edge. That request's route is wrong in the cycle after it is accepted, and a wrongly raised or missing `err_o` appears in the same cycle. A corrupted pointer register is only visible once a request probes the moved window, so the bench re-probes the edges after every reprogramming. A broken hold under backpressure shows as a route that changes while `rsp_ready` is low. A flag that is not sticky drops on the next request that does not itself abort.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int PA_W      = 36;
    localparam int SEG_ALIGN = 19;
    localparam int CFG_LOG2  = 28;
    localparam int LEN_BITS  = 6;

    typedef enum logic [1:0] {
        RT_MEM   = 2'd0,
        RT_CFG   = 2'd1,
        RT_MMIO  = 2'd2,
        RT_ABORT = 2'd3
    } route_e;

    typedef enum logic [2:0] {
        RK_READ  = 3'd0,
        RK_WRITE = 3'd1,
        RK_EWB   = 3'd2,
        RK_IWB   = 3'd3,
        RK_LOCK  = 3'd4
    } kind_e;

    typedef struct packed {
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] off;
    } cfg_fields_t;

    typedef struct packed {
        route_e      route;
        cfg_fields_t fld;
    } decision_t;

    function automatic logic is_writeback(input logic [2:0] k);
        return (k == RK_EWB) || (k == RK_IWB);
    endfunction

endpackage

// File: rtl/pmr_range_regs.sv
module pmr_range_regs
    import pmr_pkg::*;
#(
    parameter int ADDR_W = PA_W,
    parameter int ALIGN  = SEG_ALIGN,
    parameter int WIN_LG = CFG_LOG2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       tolm_i,
    input  logic                    prog_we,
    input  logic                    prog_sel,
    input  logic [ADDR_W-ALIGN-1:0] prog_data,
    output logic [ADDR_W-1:0]       top_o,
    output logic [ADDR_W-WIN_LG-1:0] cfg_base_o
);
    localparam int TOP_W = ADDR_W - ALIGN;
    localparam int CB_W  = ADDR_W - WIN_LG;

    logic [TOP_W-1:0] top_q;
    logic [CB_W-1:0]  cb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= tolm_i[ADDR_W-1:ALIGN];
            cb_q  <= tolm_i[ADDR_W-1:WIN_LG];
        end else if (prog_we) begin
            if (!prog_sel) top_q <= prog_data;
            else           cb_q  <= prog_data[TOP_W-1:TOP_W-CB_W];
        end
    end

    assign top_o      = {top_q, {ALIGN{1'b0}}};
    assign cfg_base_o = cb_q;

    // R2
    reset_top_chk: assert property (@(posedge clk)
        rst |=> (top_o[ADDR_W-1:ALIGN] == $past(tolm_i[ADDR_W-1:ALIGN])));

endmodule

// File: rtl/pmr_seg_decode.sv
module pmr_seg_decode
    import pmr_pkg::*;
#(
    parameter int ADDR_W = PA_W,
    parameter int ALIGN  = SEG_ALIGN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] first_i,
    input  logic [ADDR_W-1:0] last_i,
    input  logic [ADDR_W-1:0] top_i,
    input  logic [1:0]        size_code_i,
    output logic              hit_o,
    output logic              cross_o
);
    localparam logic [ADDR_W-1:0] ONE = 1;

    logic [ADDR_W-1:0] size;
    logic [ADDR_W-1:0] base;
    logic              in_first, in_last;

    always_comb begin
        size     = ONE << (ALIGN + int'(size_code_i));
        base     = top_i - size;
        in_first = (first_i >= base) && (first_i < top_i);
        in_last  = (last_i  >= base) && (last_i  < top_i);
    end

    assign hit_o   = in_first;
    assign cross_o = in_first ^ in_last;

    // R1
    seg_span_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ((top_i - first_i) <= (ONE << (ALIGN + 3))));

endmodule

// File: rtl/pmr_cfg_decode.sv
module pmr_cfg_decode
    import pmr_pkg::*;
#(
    parameter int ADDR_W = PA_W,
    parameter int WIN_LG = CFG_LOG2
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [ADDR_W-WIN_LG-1:0] base_i,
    output logic                     hit_o,
    output cfg_fields_t              fld_o
);
    assign hit_o = (addr_i[ADDR_W-1:WIN_LG] == base_i);
    assign fld_o = cfg_fields_t'(addr_i[WIN_LG-1:0]);
endmodule

// File: rtl/pmr_addr_router.sv
module pmr_addr_router
    import pmr_pkg::*;
#(
    parameter int ADDR_W = PA_W,
    parameter int LEN_W  = LEN_BITS,
    parameter int ALIGN  = SEG_ALIGN,
    parameter int WIN_LG = CFG_LOG2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       tolm_i,
    input  logic [1:0]              seg_size_i,
    input  logic                    prog_we,
    input  logic                    prog_sel,
    input  logic [ADDR_W-ALIGN-1:0] prog_data,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LEN_W-1:0]        req_len,
    input  logic                    req_src,
    input  logic [2:0]              req_kind,
    input  logic                    req_smq,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [1:0]              rsp_route,
    output logic [7:0]              rsp_bus,
    output logic [4:0]              rsp_dev,
    output logic [2:0]              rsp_fn,
    output logic [11:0]             rsp_off,
    output logic                    err_o,
    input  logic                    err_clr
);
    localparam int CB_W = ADDR_W - WIN_LG;

    logic [ADDR_W-1:0] top;
    logic [CB_W-1:0]   cfg_base;
    logic [ADDR_W-1:0] last_addr;
    logic              seg_hit, seg_cross, cfg_hit;
    cfg_fields_t       fld;
    decision_t         dec_d, dec_q;
    logic              err_d, err_q, vld_q, accept;

    pmr_range_regs #(.ADDR_W(ADDR_W), .ALIGN(ALIGN), .WIN_LG(WIN_LG)) u_regs (
        .clk(clk), .rst(rst), .tolm_i(tolm_i),
        .prog_we(prog_we), .prog_sel(prog_sel), .prog_data(prog_data),
        .top_o(top), .cfg_base_o(cfg_base)
    );

    assign last_addr = req_addr + {{(ADDR_W-LEN_W){1'b0}}, req_len};

    pmr_seg_decode #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_seg (
        .clk(clk), .rst(rst), .first_i(req_addr), .last_i(last_addr),
        .top_i(top), .size_code_i(seg_size_i),
        .hit_o(seg_hit), .cross_o(seg_cross)
    );

    pmr_cfg_decode #(.ADDR_W(ADDR_W), .WIN_LG(WIN_LG)) u_cfg (
        .addr_i(req_addr), .base_i(cfg_base), .hit_o(cfg_hit), .fld_o(fld)
    );

    always_comb begin
        dec_d.route = RT_MMIO;
        dec_d.fld   = '0;
        err_d       = 1'b0;
        if (req_kind == RK_LOCK && seg_cross) begin
            dec_d.route = RT_ABORT;
            err_d       = 1'b1;
        end else if (seg_hit) begin
            if (req_src)                     dec_d.route = RT_ABORT;
            else if (is_writeback(req_kind)) dec_d.route = RT_MEM;
            else if (req_smq)                dec_d.route = RT_MEM;
            else begin
                dec_d.route = RT_ABORT;
                err_d       = 1'b1;
            end
        end else if (cfg_hit) begin
            dec_d.route = RT_CFG;
            dec_d.fld   = fld;
        end else if (req_addr < tolm_i) begin
            dec_d.route = RT_MEM;
        end
    end

    assign req_ready = !vld_q || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dec_q <= '{route: RT_MEM, fld: '0};
            err_q <= 1'b0;
        end else begin
            if (accept) begin
                vld_q <= 1'b1;
                dec_q <= dec_d;
            end else if (rsp_ready) begin
                vld_q <= 1'b0;
            end
            if (accept && err_d) err_q <= 1'b1;
            else if (err_clr)    err_q <= 1'b0;
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_route = dec_q.route;
    assign rsp_bus   = dec_q.fld.bus;
    assign rsp_dev   = dec_q.fld.dev;
    assign rsp_fn    = dec_q.fld.fn;
    assign rsp_off   = dec_q.fld.off;
    assign err_o     = err_q;

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_route) && $stable(rsp_off)));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_o && !err_clr) |=> err_o);

    // R10
    err_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> rsp_valid);

    // R4
    wb_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_src && is_writeback(req_kind)) |=> (rsp_route != RT_ABORT));

    // R6
    lock_cross_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_kind == RK_LOCK && seg_cross) |=> (rsp_route == RT_ABORT && err_o));

    // R7
    fld_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route != RT_CFG) |-> (rsp_bus == 8'd0 && rsp_off == 12'd0));

endmodule

// File: tb/pmr_addr_router_tb.sv
module pmr_addr_router_tb;

    typedef struct packed {
        logic [35:0] addr;
        logic        src;
        logic [2:0]  kind;
        logic        smq;
        logic [5:0]  len;
        logic [1:0]  route;
        logic        err;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] off;
    } vec_t;

    localparam int NV = 16;
    // Defaults: tolm 0x80000000, segment 0x7FF80000..0x7FFFFFFF, cfg 0x80000000..0x8FFFFFFF
    localparam vec_t VEC [NV] = '{
        '{36'h07FF80000, 1'b0, 3'd0, 1'b1, 6'd0, 2'd0, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R1 base in
        '{36'h07FFFFFF8, 1'b0, 3'd1, 1'b0, 6'd0, 2'd3, 1'b1, 8'h0, 5'h0, 3'h0, 12'h0}, // R3 unqualified
        '{36'h07FFFFFFF, 1'b0, 3'd0, 1'b1, 6'd0, 2'd0, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R3 qualified
        '{36'h07FF7FFFF, 1'b0, 3'd0, 1'b0, 6'd0, 2'd0, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R1 below base
        '{36'h080000000, 1'b0, 3'd0, 1'b0, 6'd0, 2'd1, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R1 top excl
        '{36'h07FF90000, 1'b0, 3'd2, 1'b0, 6'd0, 2'd0, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R4 ewb
        '{36'h07FF90000, 1'b0, 3'd3, 1'b0, 6'd0, 2'd0, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R4 iwb
        '{36'h07FF90000, 1'b1, 3'd1, 1'b1, 6'd0, 2'd3, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R5 inbound
        '{36'h07FF80000, 1'b1, 3'd0, 1'b1, 6'd0, 2'd3, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R5 inbound rd
        '{36'h07FF7FFFC, 1'b0, 3'd4, 1'b1, 6'd7, 2'd3, 1'b1, 8'h0, 5'h0, 3'h0, 12'h0}, // R6 cross base
        '{36'h07FFFFFFC, 1'b0, 3'd4, 1'b1, 6'd7, 2'd3, 1'b1, 8'h0, 5'h0, 3'h0, 12'h0}, // R6 cross top
        '{36'h07FF80010, 1'b0, 3'd4, 1'b1, 6'd3, 2'd0, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R6 inside
        '{36'h090000000, 1'b0, 3'd0, 1'b0, 6'd0, 2'd2, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R8 mmio
        '{36'h000001000, 1'b1, 3'd0, 1'b0, 6'd0, 2'd0, 1'b0, 8'h0, 5'h0, 3'h0, 12'h0}, // R8 low mem
        '{36'h08ABCDEF4, 1'b0, 3'd1, 1'b0, 6'd0, 2'd1, 1'b0, 8'hAB, 5'h19, 3'h5, 12'hEF4}, // R7
        '{36'h08FFFFFFF, 1'b0, 3'd0, 1'b0, 6'd0, 2'd1, 1'b0, 8'hFF, 5'h1F, 3'h7, 12'hFFF}  // R7 top
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [35:0] tolm_i = 36'h0_8000_0000;
    logic [1:0]  seg_size_i = 2'd0;
    logic        prog_we = 1'b0, prog_sel = 1'b0;
    logic [16:0] prog_data = '0;
    logic        req_valid = 1'b0, req_ready;
    logic [35:0] req_addr = '0;
    logic [5:0]  req_len = '0;
    logic        req_src = 1'b0;
    logic [2:0]  req_kind = '0;
    logic        req_smq = 1'b0;
    logic        rsp_valid, rsp_ready = 1'b1;
    logic [1:0]  rsp_route;
    logic [7:0]  rsp_bus;
    logic [4:0]  rsp_dev;
    logic [2:0]  rsp_fn;
    logic [11:0] rsp_off;
    logic        err_o, err_clr = 1'b0;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pmr_addr_router u_dut (
        .clk(clk), .rst(rst), .tolm_i(tolm_i), .seg_size_i(seg_size_i),
        .prog_we(prog_we), .prog_sel(prog_sel), .prog_data(prog_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_src(req_src), .req_kind(req_kind), .req_smq(req_smq),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_route(rsp_route),
        .rsp_bus(rsp_bus), .rsp_dev(rsp_dev), .rsp_fn(rsp_fn), .rsp_off(rsp_off),
        .err_o(err_o), .err_clr(err_clr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [35:0] a, input logic s, input logic [2:0] k,
                        input logic q, input logic [5:0] l);
        @(negedge clk);
        req_addr = a; req_src = s; req_kind = k; req_smq = q; req_len = l;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic prog(input logic sel, input logic [35:0] a);
        @(negedge clk); prog_we = 1'b1; prog_sel = sel; prog_data = a[35:19];
        @(negedge clk); prog_we = 1'b0;
    endtask

    task automatic probe(input string tag, input logic [35:0] a, input logic q,
                         input logic [1:0] er, input logic ee);
        send(a, 1'b0, 3'd0, q, 6'd0);
        check({tag, " route"}, 64'(rsp_route), 64'(er));
        check({tag, " err"},   64'(err_o),     64'(ee));
        clear_err();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R2 err after reset", 64'(err_o), 64'd0);
        check("R9 ready idle", 64'(req_ready), 64'd1);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i].addr, VEC[i].src, VEC[i].kind, VEC[i].smq, VEC[i].len);
            check($sformatf("R8 vec%0d valid", i), 64'(rsp_valid), 64'd1);
            check($sformatf("R1 vec%0d route", i), 64'(rsp_route), 64'(VEC[i].route));
            check($sformatf("R3 vec%0d err", i), 64'(err_o), 64'(VEC[i].err));
            check($sformatf("R7 vec%0d fields", i),
                  64'({rsp_bus, rsp_dev, rsp_fn, rsp_off}),
                  64'({VEC[i].bus, VEC[i].dev, VEC[i].fn, VEC[i].off}));
            clear_err();
        end

        // R10 sticky across a clean request, then cleared
        send(36'h07FFFFFF0, 1'b0, 3'd0, 1'b0, 6'd0);
        send(36'h000002000, 1'b0, 3'd0, 1'b0, 6'd0);
        check("R10 sticky", 64'(err_o), 64'd1);
        clear_err();
        check("R10 cleared", 64'(err_o), 64'd0);

        // R10 set wins over clear in the same cycle
        @(negedge clk);
        req_addr = 36'h07FFFFFF0; req_src = 1'b0; req_kind = 3'd0; req_smq = 1'b0; req_len = '0;
        req_valid = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; err_clr = 1'b0;
        check("R10 set wins", 64'(err_o), 64'd1);
        clear_err();

        // R9 backpressure
        rsp_ready = 1'b0;
        send(36'h090000000, 1'b0, 3'd0, 1'b0, 6'd0);
        check("R9 first route", 64'(rsp_route), 64'd2);
        req_addr = 36'h000001000; req_valid = 1'b1;
        check("R9 ready low", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R9 held route", 64'(rsp_route), 64'd2);
        check("R9 held valid", 64'(rsp_valid), 64'd1);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 second route", 64'(rsp_route), 64'd0);
        @(negedge clk);
        check("R9 drained", 64'(rsp_valid), 64'd0);

        // R8 segment wins over an overlapping config window (R11 cfg base write)
        prog(1'b1, 36'h070000000);
        probe("R8 seg over cfg", 36'h07FF80000, 1'b1, 2'd0, 1'b0);
        send(36'h07FF00000, 1'b0, 3'd0, 1'b0, 6'd0);
        check("R8 cfg below seg", 64'(rsp_route), 64'd1);
        check("R7 bus field", 64'(rsp_bus), 64'hFF);

        // R11 move top pointer to 1 GB, walk size codes (R1)
        prog(1'b0, 36'h040000000);
        seg_size_i = 2'd3;
        probe("R1 4MB base", 36'h03FC00000, 1'b0, 2'd3, 1'b1);
        probe("R1 4MB below", 36'h03FBFFFFF, 1'b0, 2'd0, 1'b0);
        seg_size_i = 2'd2;
        probe("R1 2MB outside", 36'h03FD00000, 1'b0, 2'd0, 1'b0);
        probe("R1 2MB base", 36'h03FE00000, 1'b0, 2'd3, 1'b1);
        seg_size_i = 2'd1;
        probe("R1 1MB below", 36'h03FEFFFFF, 1'b0, 2'd0, 1'b0);
        probe("R1 1MB base", 36'h03FF00000, 1'b0, 2'd3, 1'b1);
        probe("R11 old seg free", 36'h07FF80000, 1'b0, 2'd1, 1'b0);

        // R11 config base above 4 GB
        prog(1'b1, 36'h100000000);
        send(36'h100100000, 1'b0, 3'd0, 1'b0, 6'd0);
        check("R11 cfg moved", 64'(rsp_route), 64'd1);
        check("R7 moved bus", 64'(rsp_bus), 64'h01);
        probe("R8 old cfg now mmio", 36'h080000000, 1'b0, 2'd2, 1'b0);

        // R2 reset restores both pointers
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        seg_size_i = 2'd0;
        check("R2 err reset", 64'(err_o), 64'd0);
        probe("R2 top restored", 36'h07FF80000, 1'b0, 2'd3, 1'b1);
        probe("R2 cfg restored", 36'h080000000, 1'b0, 2'd1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule